// File: doc/BRIEF.md
# UART Channel Interrupt Prioritizer

This block gathers every interrupt cause of one UART channel: line errors, receive data availability, a receive-idle timeout, transmit space, modem line changes, flow-control character detection, automatic flow-control pin changes and leaving sleep. It masks each cause with its own enable and keeps the enabled ones pending. It reports the most urgent of them as a six-bit status code and drives a single interrupt line.

Each cause is retired by its own side effect. Some are retired by host register accesses, such as reading the line, modem, receive or wake status, reading the status code, or writing transmit data. Others are retired by the data path, for example the receive level falling or a new character arriving. The register decoder, FIFOs and shift engines sit outside the block and appear here only as strobes and levels. The receive-idle timer counts bit-time ticks supplied by the baud logic and needs no divider of its own.

Top module: `uart_irq_top`

## Requirements
- R1: After reset no cause is pending, `isrCode` is 0x01 and `irqOut` is low.
- R2: Receive-ready is a level, not a latch. In FIFO mode (`fifoMode`=1) it is active while `rxLevel` >= `rxTrigLevel`. In non-FIFO mode it is active while `rhrFull` is high. It drops as soon as that condition ends.
- R3: A pulse on any bit of `lineErrSet` makes the line cause pending. A `lsrRead` pulse retires it.
- R4: With `rxLevel` nonzero, the timeout cause becomes pending on the edge of the bitTick pulse numbered 4*`charBits`+12, counted since the last `rxCharIn`, `rhrRead` or empty level. A `rhrRead` retires it. A received character restarts the count.
- R5: A `txTrigHit` or `txEmpty` pulse makes the transmit cause pending. A `thrWrite` retires it. An `isrRead` also retires it, but only in a cycle where transmit is the reported cause.
- R6: A pulse on any bit of `modemDelta` makes the modem cause pending. An `msrRead` retires it.
- R7: `xonHit`, `xoffHit` and `specialHit` share one cause. An `isrRead` retires all three, but only while that cause is reported. An `rxCharIn` also retires the special-character part.
- R8: A low-to-high change on `ctsDsrPin` or `rtsDtrPin` while `autoFlowEn`=1 makes the flow cause pending. The same change with `autoFlowEn`=0 does nothing. An `msrRead` retires it.
- R9: A `sleepExit` pulse makes the wake cause pending. A `wakeRead` retires it.
- R10: The cause priorities run from highest to lowest, each with its `isrCode`: line 0x06, timeout 0x0C, receive-ready 0x04, transmit 0x02, modem 0x00, Xon/Xoff/special 0x10, flow 0x20, wake 0x08. `isrCode` shows the highest enabled pending cause. A read retires only the cause it targets, so lower causes stay pending.
- R11: `irqEnable` bits 0 to 7 mask the causes in the R10 order (bit 0 line … bit 7 wake). A masked cause still latches but is neither reported nor seen on `irqOut`. `irqOut` is high whenever any enabled cause is active.
- R12: If a set event and a retiring access hit the same cause in the same cycle, the cause stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqEnable | input | 8 | Per-cause enables, bit order as R11 |
| lineErrSet | input | 4 | Line error event pulses |
| txTrigHit | input | 1 | Transmit level reached trigger |
| txEmpty | input | 1 | Transmit FIFO became empty |
| modemDelta | input | 4 | Modem line change pulses |
| xonHit | input | 1 | Xon character detected |
| xoffHit | input | 1 | Xoff character detected |
| specialHit | input | 1 | Special character detected |
| rxCharIn | input | 1 | A character entered the receive path |
| sleepExit | input | 1 | Channel left sleep |
| autoFlowEn | input | 1 | Automatic flow control active |
| ctsDsrPin | input | 1 | Selected clear/data-set-ready input level |
| rtsDtrPin | input | 1 | Selected request/terminal-ready output level |
| fifoMode | input | 1 | 1 = FIFO mode |
| rhrFull | input | 1 | Holding register has a character (non-FIFO) |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| rxTrigLevel | input | LVL_W | Receive trigger level |
| bitTick | input | 1 | One pulse per bit time |
| charBits | input | CBW | Bits per character frame |
| rhrRead | input | 1 | Receive holding register read |
| lsrRead | input | 1 | Line status read |
| msrRead | input | 1 | Modem status read |
| isrRead | input | 1 | Interrupt status read |
| thrWrite | input | 1 | Transmit holding register write |
| wakeRead | input | 1 | Wake status read |
| isrCode | output | 6 | Highest enabled pending cause code |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench keeps the default widths: a 5-bit receive level, which lets the trigger sit at 4 with room above and below, and a 4-bit frame length. A frame length of 10 gives a 52-tick idle window. That is short enough to step up to the last tick, one tick short of it, and a restart halfway through within a few hundred cycles. These settings also bring two orderings within reach: receive-ready and timeout both active at once, and a status read that hits a cause other than the reported one.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NUM_SRC = 8;
  localparam logic [5:0] CODE_NONE = 6'h01;

  typedef enum logic [2:0] {
    SRC_LINE  = 3'd0,
    SRC_TMO   = 3'd1,
    SRC_RXRDY = 3'd2,
    SRC_TX    = 3'd3,
    SRC_MODEM = 3'd4,
    SRC_XCHAR = 3'd5,
    SRC_FLOW  = 3'd6,
    SRC_WAKE  = 3'd7
  } irqSrcE;

  typedef struct packed {
    logic clrLine;
    logic clrTmo;
    logic clrTx;
    logic clrModem;
    logic clrXchar;
    logic clrSpec;
    logic clrFlow;
    logic clrWake;
    logic tmoFire;
  } clrStrbT;

  function automatic logic [5:0] srcCode(irqSrcE s);
    case (s)
      SRC_LINE:  return 6'h06;
      SRC_TMO:   return 6'h0C;
      SRC_RXRDY: return 6'h04;
      SRC_TX:    return 6'h02;
      SRC_MODEM: return 6'h00;
      SRC_XCHAR: return 6'h10;
      SRC_FLOW:  return 6'h20;
      default:   return 6'h08;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int CBW   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rhrRead,
  input  logic             lsrRead,
  input  logic             msrRead,
  input  logic             isrRead,
  input  logic             thrWrite,
  input  logic             wakeRead,
  input  logic             rxCharIn,
  input  logic             bitTick,
  input  logic [CBW-1:0]   charBits,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             reportValid,
  input  irqSrcE           reportSrc,
  output clrStrbT          strb
);
  localparam int MAX_LIMIT = 4 * ((1 << CBW) - 1) + 12;
  localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] idleLimit;
  logic             idleRestart;
  logic             isrHitsTx;
  logic             isrHitsXchar;

  assign idleLimit   = CNT_W'({charBits, 2'b00}) + CNT_W'(12);
  assign idleRestart = rhrRead || rxCharIn || (rxLevel == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (idleRestart) begin
      idleCnt <= '0;
    end else if (bitTick && idleCnt != idleLimit) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  assign isrHitsTx    = isrRead && reportValid && (reportSrc == SRC_TX);
  assign isrHitsXchar = isrRead && reportValid && (reportSrc == SRC_XCHAR);

  always_comb begin
    strb          = '0;
    strb.clrLine  = lsrRead;
    strb.clrTmo   = rhrRead;
    strb.clrTx    = thrWrite || isrHitsTx;
    strb.clrModem = msrRead;
    strb.clrXchar = isrHitsXchar;
    strb.clrSpec  = isrHitsXchar || rxCharIn;
    strb.clrFlow  = msrRead;
    strb.clrWake  = wakeRead;
    strb.tmoFire  = bitTick && !idleRestart && (idleCnt == idleLimit - 1'b1);
  end

  // R10: one status read never retires both status-read causes at once
  a_r10_isr_single_target: assert property (@(posedge clk) disable iff (!rstN)
    (isrRead && !thrWrite) |-> !(strb.clrTx && strb.clrXchar));

  // R4: the timer cannot fire in the cycle after it fired
  a_r4_fire_once: assert property (@(posedge clk) disable iff (!rstN)
    strb.tmoFire |=> !strb.tmoFire);
endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM_SRC-1:0] irqEnable,
  input  logic [3:0]       lineErrSet,
  input  logic             txTrigHit,
  input  logic             txEmpty,
  input  logic [3:0]       modemDelta,
  input  logic             xonHit,
  input  logic             xoffHit,
  input  logic             specialHit,
  input  logic             sleepExit,
  input  logic             autoFlowEn,
  input  logic             ctsDsrPin,
  input  logic             rtsDtrPin,
  input  logic             fifoMode,
  input  logic             rhrFull,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrigLevel,
  input  clrStrbT          strb,
  output logic             reportValid,
  output irqSrcE           reportSrc,
  output logic [5:0]       isrCode,
  output logic             irqOut
);
  logic lineFlag, tmoFlag, txFlag, modemFlag;
  logic xonFlag, xoffFlag, specFlag, flowFlag, wakeFlag;
  logic ctsPrev, rtsPrev, flowEdge, rxRdy;
  logic [NUM_SRC-1:0] pendV, activeV;

  assign flowEdge = autoFlowEn && ((ctsDsrPin && !ctsPrev) || (rtsDtrPin && !rtsPrev));
  assign rxRdy    = fifoMode ? (rxLevel >= rxTrigLevel) : rhrFull;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineFlag <= 1'b0; tmoFlag <= 1'b0; txFlag <= 1'b0; modemFlag <= 1'b0;
      xonFlag <= 1'b0; xoffFlag <= 1'b0; specFlag <= 1'b0;
      flowFlag <= 1'b0; wakeFlag <= 1'b0;
      ctsPrev <= 1'b0; rtsPrev <= 1'b0;
    end else begin
      ctsPrev   <= ctsDsrPin;
      rtsPrev   <= rtsDtrPin;
      lineFlag  <= (|lineErrSet) || (lineFlag && !strb.clrLine);
      tmoFlag   <= strb.tmoFire || (tmoFlag && !strb.clrTmo);
      txFlag    <= txTrigHit || txEmpty || (txFlag && !strb.clrTx);
      modemFlag <= (|modemDelta) || (modemFlag && !strb.clrModem);
      xonFlag   <= xonHit || (xonFlag && !strb.clrXchar);
      xoffFlag  <= xoffHit || (xoffFlag && !strb.clrXchar);
      specFlag  <= specialHit || (specFlag && !strb.clrSpec);
      flowFlag  <= flowEdge || (flowFlag && !strb.clrFlow);
      wakeFlag  <= sleepExit || (wakeFlag && !strb.clrWake);
    end
  end

  always_comb begin
    pendV = '0;
    pendV[SRC_LINE]  = lineFlag;
    pendV[SRC_TMO]   = tmoFlag;
    pendV[SRC_RXRDY] = rxRdy;
    pendV[SRC_TX]    = txFlag;
    pendV[SRC_MODEM] = modemFlag;
    pendV[SRC_XCHAR] = xonFlag || xoffFlag || specFlag;
    pendV[SRC_FLOW]  = flowFlag;
    pendV[SRC_WAKE]  = wakeFlag;
  end

  assign activeV = pendV & irqEnable;
  assign irqOut  = |activeV;

  always_comb begin
    reportValid = 1'b0;
    reportSrc   = SRC_LINE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (activeV[i]) begin
        reportValid = 1'b1;
        reportSrc   = irqSrcE'(3'(i));
      end
    end
    isrCode = reportValid ? srcCode(reportSrc) : CODE_NONE;
  end

  // R1/R11: an idle interrupt line goes with the none-pending code
  a_r11_idle_code: assert property (@(posedge clk) disable iff (!rstN)
    !irqOut |-> (isrCode == CODE_NONE));

  // R3/R12: a line status read with no new error retires the line cause
  a_r3_line_clear: assert property (@(posedge clk) disable iff (!rstN)
    (lsrRead_q_free()) |=> !lineFlag);

  function automatic logic lsrRead_q_free();
    return strb.clrLine && (lineErrSet == '0);
  endfunction

  // R4: the timeout cause only rises while the receive path holds data
  a_r4_tmo_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmoFlag) |-> $past(rxLevel != '0));

  // R8: the flow cause only rises while automatic flow control is on
  a_r8_flow_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flowFlag) |-> $past(autoFlowEn));

  // R9: a wake read with no new wake event retires the wake cause
  a_r9_wake_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrWake && !sleepExit) |=> !wakeFlag);
endmodule

// File: rtl/uart_irq_top.sv
module uart_irq_top
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5,
  parameter int CBW   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       irqEnable,
  input  logic [3:0]       lineErrSet,
  input  logic             txTrigHit,
  input  logic             txEmpty,
  input  logic [3:0]       modemDelta,
  input  logic             xonHit,
  input  logic             xoffHit,
  input  logic             specialHit,
  input  logic             rxCharIn,
  input  logic             sleepExit,
  input  logic             autoFlowEn,
  input  logic             ctsDsrPin,
  input  logic             rtsDtrPin,
  input  logic             fifoMode,
  input  logic             rhrFull,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] rxTrigLevel,
  input  logic             bitTick,
  input  logic [CBW-1:0]   charBits,
  input  logic             rhrRead,
  input  logic             lsrRead,
  input  logic             msrRead,
  input  logic             isrRead,
  input  logic             thrWrite,
  input  logic             wakeRead,
  output logic [5:0]       isrCode,
  output logic             irqOut
);
  clrStrbT strb;
  logic    reportValid;
  irqSrcE  reportSrc;

  uart_irq_ctrl #(.LVL_W(LVL_W), .CBW(CBW)) uCtrl (
    .clk(clk), .rstN(rstN),
    .rhrRead(rhrRead), .lsrRead(lsrRead), .msrRead(msrRead),
    .isrRead(isrRead), .thrWrite(thrWrite), .wakeRead(wakeRead),
    .rxCharIn(rxCharIn), .bitTick(bitTick), .charBits(charBits),
    .rxLevel(rxLevel), .reportValid(reportValid), .reportSrc(reportSrc),
    .strb(strb)
  );

  uart_irq_datapath #(.LVL_W(LVL_W)) uData (
    .clk(clk), .rstN(rstN), .irqEnable(irqEnable),
    .lineErrSet(lineErrSet), .txTrigHit(txTrigHit), .txEmpty(txEmpty),
    .modemDelta(modemDelta), .xonHit(xonHit), .xoffHit(xoffHit),
    .specialHit(specialHit), .sleepExit(sleepExit),
    .autoFlowEn(autoFlowEn), .ctsDsrPin(ctsDsrPin), .rtsDtrPin(rtsDtrPin),
    .fifoMode(fifoMode), .rhrFull(rhrFull), .rxLevel(rxLevel),
    .rxTrigLevel(rxTrigLevel), .strb(strb),
    .reportValid(reportValid), .reportSrc(reportSrc),
    .isrCode(isrCode), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_uart_irq_top.sv
module tb_uart_irq_top;
  localparam int LVL_W = 5;
  localparam int CBW   = 4;

  logic clk = 1'b0;
  logic rstN;
  logic [7:0] irqEnable;
  logic [3:0] lineErrSet, modemDelta;
  logic txTrigHit, txEmpty, xonHit, xoffHit, specialHit, rxCharIn, sleepExit;
  logic autoFlowEn, ctsDsrPin, rtsDtrPin, fifoMode, rhrFull, bitTick;
  logic [LVL_W-1:0] rxLevel, rxTrigLevel;
  logic [CBW-1:0] charBits;
  logic rhrRead, lsrRead, msrRead, isrRead, thrWrite, wakeRead;
  logic [5:0] isrCode;
  logic irqOut;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  uart_irq_top #(.LVL_W(LVL_W), .CBW(CBW)) dut (
    .clk(clk), .rstN(rstN), .irqEnable(irqEnable), .lineErrSet(lineErrSet),
    .txTrigHit(txTrigHit), .txEmpty(txEmpty), .modemDelta(modemDelta),
    .xonHit(xonHit), .xoffHit(xoffHit), .specialHit(specialHit),
    .rxCharIn(rxCharIn), .sleepExit(sleepExit), .autoFlowEn(autoFlowEn),
    .ctsDsrPin(ctsDsrPin), .rtsDtrPin(rtsDtrPin), .fifoMode(fifoMode),
    .rhrFull(rhrFull), .rxLevel(rxLevel), .rxTrigLevel(rxTrigLevel),
    .bitTick(bitTick), .charBits(charBits), .rhrRead(rhrRead),
    .lsrRead(lsrRead), .msrRead(msrRead), .isrRead(isrRead),
    .thrWrite(thrWrite), .wakeRead(wakeRead), .isrCode(isrCode), .irqOut(irqOut)
  );

  // vector: enable[8] | events[8] | accesses[6] | expected code[6] | expected irq[1]
  // events: 0 line, 1 txEmpty, 2 modem, 3 xon, 4 sleepExit, 5 special, 6 rxChar, 7 txTrig
  // accesses: 0 rhrRead, 1 msrRead, 2 lsrRead, 3 isrRead, 4 thrWrite, 5 wakeRead
  localparam int NVEC = 19;
  localparam logic [28:0] VEC [NVEC] = '{
    {8'hFF, 8'h00, 6'h00, 6'h01, 1'b0},  // R1 idle
    {8'hFF, 8'h02, 6'h00, 6'h02, 1'b1},  // R5 tx empty
    {8'hFF, 8'h01, 6'h00, 6'h06, 1'b1},  // R3 R10 line above tx
    {8'hFF, 8'h00, 6'h08, 6'h06, 1'b1},  // R10 status read while line reported: tx kept
    {8'hFF, 8'h00, 6'h04, 6'h02, 1'b1},  // R3 line retired
    {8'hFF, 8'h04, 6'h00, 6'h02, 1'b1},  // R6 R10 modem below tx
    {8'hFF, 8'h00, 6'h08, 6'h00, 1'b1},  // R5 status read retires tx
    {8'hFF, 8'h00, 6'h02, 6'h01, 1'b0},  // R6 modem retired
    {8'hFF, 8'h20, 6'h00, 6'h10, 1'b1},  // R7 special
    {8'hFF, 8'h40, 6'h00, 6'h01, 1'b0},  // R7 next char retires special
    {8'hFF, 8'h08, 6'h00, 6'h10, 1'b1},  // R7 xon
    {8'hFF, 8'h00, 6'h08, 6'h01, 1'b0},  // R7 status read retires xon
    {8'h00, 8'h10, 6'h00, 6'h01, 1'b0},  // R11 wake masked
    {8'h80, 8'h00, 6'h00, 6'h08, 1'b1},  // R9 R11 wake unmasked
    {8'h80, 8'h00, 6'h20, 6'h01, 1'b0},  // R9 wake read
    {8'hFF, 8'h80, 6'h10, 6'h02, 1'b1},  // R12 trigger and write together
    {8'hFF, 8'h00, 6'h10, 6'h01, 1'b0},  // R5 write retires tx
    {8'hFF, 8'h01, 6'h04, 6'h06, 1'b1},  // R12 error and read together
    {8'hFF, 8'h00, 6'h04, 6'h01, 1'b0}   // R3 retire
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clearPulses();
    lineErrSet = '0; modemDelta = '0; txTrigHit = 0; txEmpty = 0;
    xonHit = 0; xoffHit = 0; specialHit = 0; rxCharIn = 0; sleepExit = 0;
    rhrRead = 0; lsrRead = 0; msrRead = 0; isrRead = 0; thrWrite = 0;
    wakeRead = 0; bitTick = 0;
  endtask

  task automatic check(string req, logic [5:0] expCode, logic expIrq);
    nChecks++;
    if (isrCode !== expCode || irqOut !== expIrq) begin
      nFails++;
      $display("FAIL %s: code=%h irq=%b expected code=%h irq=%b",
               req, isrCode, irqOut, expCode, expIrq);
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) begin
      bitTick = 1; tick(); bitTick = 0;
    end
  endtask

  initial begin
    #(8 * 200000);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    clearPulses();
    rstN = 0; irqEnable = 8'hFF; autoFlowEn = 0; ctsDsrPin = 0; rtsDtrPin = 0;
    fifoMode = 1; rhrFull = 0; rxLevel = '0; rxTrigLevel = 5'd4; charBits = 4'd10;
    tick(); tick();
    rstN = 1;
    tick();
    check("R1 reset", 6'h01, 1'b0);

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] en, ev;
      logic [5:0] acc;
      en = VEC[v][28:21]; ev = VEC[v][20:13]; acc = VEC[v][12:7];
      irqEnable = en;
      lineErrSet = {3'b0, ev[0]}; txEmpty = ev[1]; modemDelta = {3'b0, ev[2]};
      xonHit = ev[3]; sleepExit = ev[4]; specialHit = ev[5]; rxCharIn = ev[6];
      txTrigHit = ev[7];
      rhrRead = acc[0]; msrRead = acc[1]; lsrRead = acc[2]; isrRead = acc[3];
      thrWrite = acc[4]; wakeRead = acc[5];
      tick();
      clearPulses();
      check($sformatf("vector %0d (R1..R12 table)", v), VEC[v][6:1], VEC[v][0]);
    end
    irqEnable = 8'hFF;

    // R7 xoff shares the character cause
    xoffHit = 1; tick(); clearPulses();
    check("R7 xoff", 6'h10, 1'b1);
    isrRead = 1; tick(); clearPulses();
    check("R7 xoff retired", 6'h01, 1'b0);

    // R2 receive-ready level in both modes
    rxLevel = 5'd3; #1;
    check("R2 below trigger", 6'h01, 1'b0);
    rxLevel = 5'd4; #1;
    check("R2 at trigger", 6'h04, 1'b1);
    rxLevel = 5'd3; #1;
    check("R2 drop below trigger", 6'h01, 1'b0);
    fifoMode = 0; rxLevel = '0; rhrFull = 1; #1;
    check("R2 non-fifo holding full", 6'h04, 1'b1);
    rhrFull = 0; fifoMode = 1; #1;
    check("R2 holding empty", 6'h01, 1'b0);

    // R4 idle timeout: 4*10+12 = 52 ticks
    rxLevel = 5'd1; tick();
    ticks(51);
    check("R4 one tick short", 6'h01, 1'b0);
    ticks(1);
    check("R4 window reached", 6'h0C, 1'b1);
    rxLevel = 5'd4; #1;
    check("R4 R10 timeout above rx ready", 6'h0C, 1'b1);
    rxLevel = 5'd1;
    rhrRead = 1; tick(); clearPulses();
    check("R4 receive read retires", 6'h01, 1'b0);
    ticks(30);
    rxCharIn = 1; tick(); clearPulses();
    ticks(30);
    check("R4 char restarts window", 6'h01, 1'b0);
    ticks(22);
    check("R4 restarted window reached", 6'h0C, 1'b1);
    rhrRead = 1; rxLevel = '0; tick(); clearPulses();
    check("R4 retired", 6'h01, 1'b0);

    // R8 flow pin edges
    ctsDsrPin = 1; tick(); tick();
    check("R8 edge ignored when disabled", 6'h01, 1'b0);
    ctsDsrPin = 0; tick();
    autoFlowEn = 1; rtsDtrPin = 1; tick();
    check("R8 edge while enabled", 6'h20, 1'b1);
    msrRead = 1; tick(); clearPulses();
    check("R8 modem read retires", 6'h01, 1'b0);

    // R11 masked cause latches and appears when unmasked
    irqEnable = 8'hEF; modemDelta = 4'h8; tick(); clearPulses();
    check("R11 modem masked", 6'h01, 1'b0);
    irqEnable = 8'hFF; #1;
    check("R11 modem unmasked", 6'h00, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule